// File: doc/BRIEF.md
# Complementary-Redundant Permutation Engine with Fault Check

This block runs a 320-bit sponge-style permutation on five 64-bit words and keeps two copies of the state while it does so. One copy holds the true value. The other holds the bitwise inverse, and a separate dual network updates it. In that network every constant is inverted, every AND becomes OR, and every XOR becomes XNOR. A single round is applied per clock cycle, and the number of rounds comes from an input. Each round has three steps: it adds a round constant, it applies a 5-bit substitution across 64 bit-slices, and it mixes each word with two of its own rotations.

The engine copies both state copies into checkpoint registers as the last round is about to run. When the run ends, it XORs the true result with the complement result. If any bit of that XOR is not 1, it raises the fault flag for one cycle. It then reloads the checkpoint, computes the final round again and repeats the check. If the second check also fails, the engine stops with the fault flag held high and the result forced to zero. A faulty state therefore never reaches the output.

The control state machine has six states:
- IDLE: waits for `start`.
- RUN: applies one round per cycle and goes to CHECK after the last round.
- CHECK: goes to PASS on a match. On a mismatch it goes to REDO the first time and to FAIL the second time.
- REDO: recomputes the last round from the checkpoint and returns to CHECK.
- PASS and FAIL: hold their outputs until a new `start` begins another run (transition to RUN).

Top module: `cperm_core`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0, `fault` is 0 and `result_o` is all zeros.
- R2: For an effective round count n, round r (0 ≤ r < n) uses index i = 12 − n + r and XORs the 8-bit constant {15 − i, i} (high nibble, low nibble) into bits [7:0] of word 2. Word k occupies bits [64k+63:64k]. The round then applies the substitution and the rotations (19,28), (61,39), (1,6), (10,17), (7,41) to words 0 to 4 in turn. With no fault, `result_o` equals this permutation of `state_i`.
- R3: A round-count input of 0 is treated as 1 round, and values above 12 are treated as 12 rounds.
- R4: With no fault, `done` first rises after the (n+1)-th rising edge following the edge that samples `start`.
- R5: `start` is ignored while a run is in progress: result and latency are unchanged. Once `done` is high it stays high until `start` is sampled.
- R6: Whenever a valid result is presented, the true state and the complement state differ in every bit.
- R7: A corruption of the true state after the checkpoint raises `fault` for exactly one cycle, right after the first check. `done` then rises after the (n+3)-th edge with the correct result and `fault` low.
- R8: A corruption before the checkpoint fails both checks. `done` and `fault` then rise together after the (n+3)-th edge and stay high until the next `start`.
- R9: `result_o` is all zeros unless `done` is 1 and `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled in IDLE, PASS or FAIL |
| rounds_i | input | 4 | Requested round count, clamped to 1..12 |
| state_i | input | 320 | Input state, word k at bits [64k+63:64k] |
| result_o | output | 320 | Permuted state, zero unless the result is valid |
| done | output | 1 | Run finished (PASS or FAIL) |
| fault | output | 1 | Mismatch seen (one cycle in REDO, held in FAIL) |

## Verification
The assertions assume that `start`, `rounds_i` and `state_i` are free of X when sampled. They also assume that a fault appears only as a corruption of the true state register, never of both copies in a matching way. The stimulus drives its inputs only on falling edges. It injects faults by overwriting the true state once: in one scenario inside the final CHECK cycle, and in the other during an early round, before the checkpoint is taken. This keeps every injected error detectable by the complement comparison.

// File: rtl/cperm_pkg.sv
package cperm_pkg;
    localparam int WORDS   = 5;
    localparam int WORD_W  = 64;
    localparam int STATE_W = WORDS * WORD_W;
    localparam int MAX_RND = 12;
    localparam int RND_W   = 4;
    localparam int RC_W    = 8;
    localparam int RC_WORD = 2;

    localparam int unsigned ROT_A [WORDS] = '{19, 61, 1, 10, 7};
    localparam int unsigned ROT_B [WORDS] = '{28, 39, 6, 17, 41};

    typedef enum logic [2:0] {
        PH_IDLE, PH_RUN, PH_CHECK, PH_REDO, PH_PASS, PH_FAIL
    } phase_t;

    function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v, input int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    function automatic logic [RC_W-1:0] round_const(input logic [RND_W-1:0] idx);
        return {~idx, idx};
    endfunction
endpackage

// File: rtl/cperm_round_true.sv
module cperm_round_true
    import cperm_pkg::*;
(
    input  logic [STATE_W-1:0] s_i,
    input  logic [RC_W-1:0]    rc_i,
    output logic [STATE_W-1:0] s_o
);
    logic [WORDS-1:0][WORD_W-1:0] xw;
    logic [WORDS-1:0][WORD_W-1:0] sw;

    for (genvar w = 0; w < WORDS; w++) begin : g_in
        if (w == RC_WORD) begin : g_rc
            assign xw[w] = s_i[w*WORD_W +: WORD_W] ^ {{(WORD_W-RC_W){1'b0}}, rc_i};
        end else begin : g_pass
            assign xw[w] = s_i[w*WORD_W +: WORD_W];
        end
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_slice
        logic a0, a1, a2, a3, a4, m0, m1, m2, m3, m4;
        assign a0 = xw[0][b] ^ xw[4][b];
        assign a1 = xw[1][b];
        assign a2 = xw[2][b] ^ xw[1][b];
        assign a3 = xw[3][b];
        assign a4 = xw[4][b] ^ xw[3][b];
        assign m0 = a0 ^ (~a1 & a2);
        assign m1 = a1 ^ (~a2 & a3);
        assign m2 = a2 ^ (~a3 & a4);
        assign m3 = a3 ^ (~a4 & a0);
        assign m4 = a4 ^ (~a0 & a1);
        assign sw[0][b] = m0 ^ m4;
        assign sw[1][b] = m1 ^ m0;
        assign sw[2][b] = ~m2;
        assign sw[3][b] = m3 ^ m2;
        assign sw[4][b] = m4;
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_mix
        assign s_o[w*WORD_W +: WORD_W] = sw[w] ^ rotr(sw[w], ROT_A[w]) ^ rotr(sw[w], ROT_B[w]);
    end
endmodule

// File: rtl/cperm_round_dual.sv
module cperm_round_dual
    import cperm_pkg::*;
(
    input  logic [STATE_W-1:0] z_i,
    input  logic [RC_W-1:0]    rc_i,
    output logic [STATE_W-1:0] z_o
);
    logic [WORDS-1:0][WORD_W-1:0] xw;
    logic [WORDS-1:0][WORD_W-1:0] sw;

    for (genvar w = 0; w < WORDS; w++) begin : g_in
        if (w == RC_WORD) begin : g_rc
            assign xw[w] = z_i[w*WORD_W +: WORD_W] ~^ ~{{(WORD_W-RC_W){1'b0}}, rc_i};
        end else begin : g_pass
            assign xw[w] = z_i[w*WORD_W +: WORD_W];
        end
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_slice
        logic a0, a1, a2, a3, a4, m0, m1, m2, m3, m4;
        assign a0 = xw[0][b] ~^ xw[4][b];
        assign a1 = xw[1][b];
        assign a2 = xw[2][b] ~^ xw[1][b];
        assign a3 = xw[3][b];
        assign a4 = xw[4][b] ~^ xw[3][b];
        assign m0 = a0 ~^ (~a1 | a2);
        assign m1 = a1 ~^ (~a2 | a3);
        assign m2 = a2 ~^ (~a3 | a4);
        assign m3 = a3 ~^ (~a4 | a0);
        assign m4 = a4 ~^ (~a0 | a1);
        assign sw[0][b] = m0 ~^ m4;
        assign sw[1][b] = m1 ~^ m0;
        assign sw[2][b] = ~m2;
        assign sw[3][b] = m3 ~^ m2;
        assign sw[4][b] = m4;
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_mix
        assign z_o[w*WORD_W +: WORD_W] = (sw[w] ~^ rotr(sw[w], ROT_A[w])) ~^ rotr(sw[w], ROT_B[w]);
    end
endmodule

// File: rtl/cperm_core.sv
module cperm_core
    import cperm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [RND_W-1:0]   rounds_i,
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] result_o,
    output logic               done,
    output logic               fault
);
    phase_t             ph_q, ph_d;
    logic [RND_W-1:0]   rnd_q, nr_q, nr_ld, idx;
    logic               retry_q;
    logic [STATE_W-1:0] st_q, cs_q, ck_t_q, ck_c_q;
    logic [STATE_W-1:0] rt_in, rd_in, rt_out, rd_out;
    logic               last_rnd, match, load;

    assign nr_ld = (rounds_i == '0) ? RND_W'(1) :
                   (rounds_i > RND_W'(MAX_RND)) ? RND_W'(MAX_RND) : rounds_i;
    assign last_rnd = (rnd_q == nr_q - RND_W'(1));
    assign match    = &(st_q ^ cs_q);
    assign load     = start && (ph_q == PH_IDLE || ph_q == PH_PASS || ph_q == PH_FAIL);
    assign idx      = (ph_q == PH_REDO) ? RND_W'(MAX_RND - 1)
                                        : RND_W'(MAX_RND) - nr_q + rnd_q;
    assign rt_in    = (ph_q == PH_REDO) ? ck_t_q : st_q;
    assign rd_in    = (ph_q == PH_REDO) ? ck_c_q : cs_q;

    cperm_round_true u_true (.s_i(rt_in), .rc_i(round_const(idx)), .s_o(rt_out));
    cperm_round_dual u_dual (.z_i(rd_in), .rc_i(round_const(idx)), .z_o(rd_out));

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (start) ph_d = PH_RUN;
            PH_RUN:   if (last_rnd) ph_d = PH_CHECK;
            PH_CHECK: ph_d = match ? PH_PASS : (retry_q ? PH_FAIL : PH_REDO);
            PH_REDO:  ph_d = PH_CHECK;
            PH_PASS:  if (start) ph_d = PH_RUN;
            PH_FAIL:  if (start) ph_d = PH_RUN;
            default:  ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd_q   <= '0;
            nr_q    <= RND_W'(1);
            retry_q <= 1'b0;
        end else if (load) begin
            rnd_q   <= '0;
            nr_q    <= nr_ld;
            retry_q <= 1'b0;
        end else if (ph_q == PH_RUN) begin
            rnd_q   <= rnd_q + RND_W'(1);
        end else if (ph_q == PH_REDO) begin
            retry_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            st_q <= state_i;
            cs_q <= ~state_i;
        end else if (ph_q == PH_RUN || ph_q == PH_REDO) begin
            st_q <= rt_out;
            cs_q <= rd_out;
        end
        if (ph_q == PH_RUN && last_rnd) begin
            ck_t_q <= st_q;
            ck_c_q <= cs_q;
        end
    end

    always_comb begin
        done     = (ph_q == PH_PASS) || (ph_q == PH_FAIL);
        fault    = (ph_q == PH_REDO) || (ph_q == PH_FAIL);
        result_o = (ph_q == PH_PASS) ? st_q : '0;
    end
endmodule

// File: rtl/cperm_core_chk.sv
module cperm_core_chk
    import cperm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic               fault,
    input logic [STATE_W-1:0] result_o,
    input logic [STATE_W-1:0] st_q,
    input logic [STATE_W-1:0] cs_q,
    input logic [RND_W-1:0]   rnd_q,
    input logic [RND_W-1:0]   nr_q
);
    // R3
    round_range_chk: assert property (@(posedge clk) disable iff (rst)
        (nr_q >= RND_W'(1)) && (nr_q <= RND_W'(MAX_RND)) && (rnd_q <= nr_q));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R6
    dual_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (&(st_q ^ cs_q)));

    // R7
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !done) |=> !fault);

    // R9
    masked_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && !fault) |-> (result_o == '0));
endmodule

bind cperm_core cperm_core_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done), .fault(fault),
    .result_o(result_o), .st_q(st_q), .cs_q(cs_q), .rnd_q(rnd_q), .nr_q(nr_q)
);

// File: tb/cperm_core_bench.sv
`timescale 1ns/1ps
module cperm_core_bench;
    import cperm_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [RND_W-1:0]   rounds_i = '0;
    logic [STATE_W-1:0] state_i = '0;
    logic [STATE_W-1:0] result_o;
    logic               done, fault;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [STATE_W-1:0] st;
        logic               flt;
        int                 req;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    cperm_core u_cperm_core (
        .clk(clk), .rst(rst), .start(start), .rounds_i(rounds_i),
        .state_i(state_i), .result_o(result_o), .done(done), .fault(fault)
    );

    task automatic check(input bit ok, input string tag, input logic [STATE_W-1:0] act,
                         input logic [STATE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rr(input logic [63:0] v, input int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    function automatic logic [STATE_W-1:0] ref_perm(input logic [STATE_W-1:0] s, input int n);
        logic [63:0] x [5];
        logic [63:0] t [5];
        logic [STATE_W-1:0] o;
        for (int w = 0; w < 5; w++) x[w] = s[w*64 +: 64];
        for (int r = 0; r < n; r++) begin
            int i = 12 - n + r;
            x[2] = x[2] ^ {56'h0, 4'(15 - i), 4'(i)};
            x[0] ^= x[4]; x[4] ^= x[3]; x[2] ^= x[1];
            for (int k = 0; k < 5; k++) t[k] = ~x[k] & x[(k + 1) % 5];
            for (int k = 0; k < 5; k++) x[k] ^= t[(k + 1) % 5];
            x[1] ^= x[0]; x[0] ^= x[4]; x[3] ^= x[2]; x[2] = ~x[2];
            x[0] = x[0] ^ rr(x[0], 19) ^ rr(x[0], 28);
            x[1] = x[1] ^ rr(x[1], 61) ^ rr(x[1], 39);
            x[2] = x[2] ^ rr(x[2], 1)  ^ rr(x[2], 6);
            x[3] = x[3] ^ rr(x[3], 10) ^ rr(x[3], 17);
            x[4] = x[4] ^ rr(x[4], 7)  ^ rr(x[4], 41);
        end
        for (int w = 0; w < 5; w++) o[w*64 +: 64] = x[w];
        return o;
    endfunction

    // Monitor: pops one expected item at each rising of done
    initial begin
        logic seen;
        seen = 1'b0;
        forever begin
            @(negedge clk);
            if (done && !seen) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected result", result_o, '0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(result_o == e.st, $sformatf("R%0d result", e.req), result_o, e.st);
                    check(fault == e.flt, $sformatf("R%0d fault flag", e.req),
                          STATE_W'(fault), STATE_W'(e.flt));
                end
            end
            seen = done;
        end
    end

    // mode 0: clean, 1: late corruption (R7), 2: early corruption (R8), 3: stray start (R5)
    task automatic run(input logic [STATE_W-1:0] s, input logic [RND_W-1:0] n,
                       input int mode, input int req);
        int eff, lat, k;
        bit got;
        exp_t e;
        eff = (n == 0) ? 1 : (n > 12) ? 12 : int'(n);
        lat = (mode == 1 || mode == 2) ? eff + 3 : eff + 1;
        e.st  = (mode == 2) ? '0 : ref_perm(s, eff);
        e.flt = (mode == 2);
        e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        state_i = s; rounds_i = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0; state_i = ~s; rounds_i = 4'd3;
        k = 0; got = 1'b0;
        while (!got && k < 64) begin
            @(negedge clk);
            k++;
            if (k == 1 && !done)
                check(result_o == '0, "R9 output masked while busy", result_o, '0);
            if (mode == 3 && k == 2) begin start = 1'b1; state_i = {STATE_W{1'b1}}; end
            if (mode == 3 && k == 3) start = 1'b0;
            if (mode == 1 && k == eff + 1)
                check(fault && !done, "R7 fault pulse after first check",
                      STATE_W'({fault, done}), STATE_W'(2'b10));
            if (mode == 1 && k == eff + 2)
                check(!fault, "R7 fault lasts one cycle", STATE_W'(fault), '0);
            if (done) begin
                got = 1'b1;
                check(k == lat, $sformatf("R%0d latency", (mode == 0 || mode == 3) ? 4 : req),
                      STATE_W'(k), STATE_W'(lat));
            end
            if ((mode == 1 && k == eff) || (mode == 2 && k == 1)) begin
                force u_cperm_core.st_q = '0;
                #1;
                release u_cperm_core.st_q;
            end
        end
        repeat (2) begin
            @(negedge clk);
            check(done && (fault == (mode == 2)), "R5 done and fault held",
                  STATE_W'({done, fault}), STATE_W'({1'b1, mode == 2}));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog: actual hung expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [STATE_W-1:0] pa, pb, pc;
        pa = {64'h0123456789abcdef, 64'hfedcba9876543210, 64'h0f0f0f0f0f0f0f0f,
              64'hdeadbeefcafef00d, 64'h8000000000000001};
        pb = {5{64'h5555aaaa3333cccc}};
        pc = {64'h1, 64'h2, 64'h3, 64'h4, 64'h5};
        repeat (3) @(negedge clk);
        // R1
        check(done == 1'b0, "R1 done after reset", STATE_W'(done), '0);
        check(fault == 1'b0, "R1 fault after reset", STATE_W'(fault), '0);
        check(result_o == '0, "R1 result after reset", result_o, '0);
        rst = 1'b0;
        run(pa, 4'd12, 0, 2);             // R2 full run
        run('0, 4'd12, 0, 2);             // R2 zero state
        run({STATE_W{1'b1}}, 4'd6, 0, 2); // R2 all ones
        run(pb, 4'd8, 0, 2);              // R2 eight rounds
        run(pc, 4'd1, 0, 2);              // R2 single round
        run(pa, 4'd0, 0, 3);              // R3 zero clamps to one
        run(pb, 4'd15, 0, 3);             // R3 large clamps to twelve
        run(pc, 4'd12, 3, 5);             // R5 stray start ignored
        run(pa, 4'd12, 1, 7);             // R7 recover
        run(pb, 4'd6, 1, 7);              // R7 recover, short run
        run(pc, 4'd12, 2, 8);             // R8 persistent fault
        run(pb, 4'd8, 0, 2);              // R2 normal after FAIL
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2 all results seen", STATE_W'(sb_q.size()), '0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule